// File: doc/BRIEF.md
# Byte-Serial ROM Programming Pulse Sequencer

The sequencer drives the digital side of a session that programs a 2048 x 8 UV-erasable ROM one byte at a time. A session begins with a start request. The block turns on the programming-voltage enable and drives the output-enable line high, and it keeps both in that state while bytes are written. It then takes location/value pairs from a valid/ready stream. For each accepted pair it puts the location on the address output first and the value on the data output second. It then issues one long, fixed-width, positive program pulse and holds everything steady for a hold interval.

The pulse lasts 50 ms by default. The block converts that time to a cycle count from a clock-frequency parameter. The setup and hold intervals are parameters given in cycles. When a pair marked last has been handled, the block removes the programming-voltage enable, raises done for one cycle and returns to idle. A pair whose location lies outside the device is refused with a one-cycle error flag, and no pulse is issued for it. A counter reports how many locations the current session has programmed.

Top module: `prom_burn_seq`

## Requirements
- R1: After reset the pulse, voltage enable, output enable, ready, busy, done and error outputs are all 0, and the count, address and data outputs are 0.
- R2: One cycle after a start request in idle, both the voltage enable and the output enable are 1, and busy is 1. Ready first becomes 1 SETUP_CYC+1 cycles after the request. The voltage enable and output enable stay 1 during every program pulse.
- R3: For each accepted pair, the address output takes the new location SETUP_CYC cycles before the data output takes the new value.
- R4: Each correctly addressed pair produces exactly one program pulse, high for CLK_HZ/1000*PULSE_MS cycles (1000 cycles with the bench parameters).
- R5: The pulse rises SETUP_CYC cycles after the data output changes. Address and data do not change while the pulse is high.
- R6: After the pulse falls, address and data are held for HOLD_CYC cycles. At the end of that time either ready returns or the session ends.
- R7: Ready is 1 only while the sequencer waits for a pair, and a pair is taken only on a cycle with valid and ready both 1. A valid held while a byte is in progress causes no second pulse.
- R8: After the hold of a pair marked last, done is 1 for exactly one cycle, with the voltage enable already 0. On the next cycle busy and the output enable are 0.
- R9: A pair whose 12-bit location has bit 11 set (value above 2047) raises the error output for one cycle. It issues no pulse, leaves the count and the address output unchanged, and still ends the session if it is marked last.
- R10: The count output is cleared by a session start and rises by one when each program pulse ends.
- R11: A start request while busy is ignored. The running session continues and its count is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Session start request, acted on only when idle |
| in_valid_i | input | 1 | Pair stream valid |
| in_ready_o | output | 1 | Pair stream ready |
| in_addr_i | input | 12 | Requested location; values of 2048 and up are refused |
| in_data_i | input | 8 | Byte value to program |
| in_last_i | input | 1 | Marks the final pair of the session |
| prog_addr_o | output | 11 | Address lines to the device |
| prog_data_o | output | 8 | Data lines to the device |
| prog_pulse_o | output | 1 | Positive program pulse |
| vpp_en_o | output | 1 | Programming-voltage supply enable |
| oe_o | output | 1 | Output-enable line, held high through a session |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle end-of-session strobe |
| err_o | output | 1 | One-cycle flag for a refused pair |
| count_o | output | 12 | Locations programmed in the current session |

## Verification
The assertions assume that the reset is asserted from time zero. They also assume the stream obeys valid/ready rules: a pair is only counted as transferred on a cycle where ready is high. The pulse-width and stability properties depend on the setup, hold and pulse parameters all being at least one cycle. The bench keeps to these rules. It changes inputs only on falling clock edges. It keeps valid and the pair fields constant until it has seen ready at a falling edge, then drops valid one cycle later. It uses different locations and values for consecutive pairs, so that every address and data change can be seen at the outputs.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_WAIT,
        ST_ADDR,
        ST_DATA,
        ST_PULSE,
        ST_HOLD,
        ST_FIN
    } pbs_state_e;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pbs_tick_cnt.sv
module pbs_tick_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pbs_range_chk.sv
module pbs_range_chk #(
    parameter int IN_W   = 12,
    parameter int ADDR_W = 11,
    parameter int DEPTH  = 2048
) (
    input  logic [IN_W-1:0]   addr_i,
    output logic              ok_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [IN_W-1:0] LIMIT = IN_W'(DEPTH);

    assign ok_o   = (addr_i < LIMIT);
    assign addr_o = addr_i[ADDR_W-1:0];

endmodule

// File: rtl/prom_burn_seq.sv
module prom_burn_seq #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int PULSE_MS  = 50,
    parameter int SETUP_CYC = 4,
    parameter int HOLD_CYC  = 4,
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int IN_W      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [IN_W-1:0]   in_addr_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_last_i,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [DATA_W-1:0] prog_data_o,
    output logic              prog_pulse_o,
    output logic              vpp_en_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [IN_W-1:0]   count_o
);

    import pbs_pkg::*;

    localparam int DEPTH     = 1 << ADDR_W;
    localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_MS;
    localparam int MAX_SPAN  = int'(max3(PULSE_CYC, SETUP_CYC, HOLD_CYC));
    localparam int CNT_W     = $clog2(MAX_SPAN + 1);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        pbs_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] data_pend;
        logic              last;
        logic              err;
        logic [IN_W-1:0]   count;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic              tmr_load_d;
    logic [CNT_W-1:0]  tmr_val_d;
    logic              tmr_zero;
    logic              addr_ok;
    logic [ADDR_W-1:0] addr_trunc;
    logic              take;

    pbs_range_chk #(
        .IN_W   (IN_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) range_i (
        .addr_i (in_addr_i),
        .ok_o   (addr_ok),
        .addr_o (addr_trunc)
    );

    pbs_tick_cnt #(
        .CNT_W (CNT_W)
    ) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load_d),
        .load_val_i (tmr_val_d),
        .zero_o     (tmr_zero)
    );

    assign take = in_valid_i && (cur_q.state == ST_WAIT);

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.err  = 1'b0;
        tmr_load_d = 1'b0;
        tmr_val_d  = '0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    nxt_d.state = ST_ARM;
                    nxt_d.count = '0;
                    nxt_d.last  = 1'b0;
                    tmr_load_d  = 1'b1;
                    tmr_val_d   = LD_SETUP;
                end
            end
            ST_ARM: begin
                if (tmr_zero) begin
                    nxt_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (take) begin
                    nxt_d.last = in_last_i;
                    if (addr_ok) begin
                        nxt_d.addr      = addr_trunc;
                        nxt_d.data_pend = in_data_i;
                        nxt_d.state     = ST_ADDR;
                        tmr_load_d      = 1'b1;
                        tmr_val_d       = LD_SETUP;
                    end else begin
                        nxt_d.err = 1'b1;
                        if (in_last_i) begin
                            nxt_d.state = ST_FIN;
                        end
                    end
                end
            end
            ST_ADDR: begin
                if (tmr_zero) begin
                    nxt_d.data  = cur_q.data_pend;
                    nxt_d.state = ST_DATA;
                    tmr_load_d  = 1'b1;
                    tmr_val_d   = LD_SETUP;
                end
            end
            ST_DATA: begin
                if (tmr_zero) begin
                    nxt_d.state = ST_PULSE;
                    tmr_load_d  = 1'b1;
                    tmr_val_d   = LD_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    nxt_d.state = ST_HOLD;
                    tmr_load_d  = 1'b1;
                    tmr_val_d   = LD_HOLD;
                    if (cur_q.count != '1) begin
                        nxt_d.count = cur_q.count + IN_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    nxt_d.state = cur_q.last ? ST_FIN : ST_WAIT;
                end
            end
            ST_FIN: begin
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, addr: '0, data: '0, data_pend: '0,
                       last: 1'b0, err: 1'b0, count: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign in_ready_o   = (cur_q.state == ST_WAIT);
    assign prog_addr_o  = cur_q.addr;
    assign prog_data_o  = cur_q.data;
    assign prog_pulse_o = (cur_q.state == ST_PULSE);
    assign vpp_en_o     = (cur_q.state != ST_IDLE) && (cur_q.state != ST_FIN);
    assign oe_o         = (cur_q.state != ST_IDLE);
    assign busy_o       = (cur_q.state != ST_IDLE);
    assign done_o       = (cur_q.state == ST_FIN);
    assign err_o        = cur_q.err;
    assign count_o      = cur_q.count;

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int PULSE_CYC = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_pulse_o,
    input logic              vpp_en_o,
    input logic              oe_o,
    input logic              in_ready_o,
    input logic              done_o,
    input logic              err_o,
    input logic [ADDR_W-1:0] prog_addr_o,
    input logic [DATA_W-1:0] prog_data_o
);

    localparam int WW = $clog2(PULSE_CYC + 2);

    logic [WW-1:0] width_q;
    logic          pulse_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q      <= '0;
            pulse_prev_q <= 1'b0;
        end else begin
            pulse_prev_q <= prog_pulse_o;
            if (prog_pulse_o) begin
                width_q <= pulse_prev_q ? (width_q + WW'(1)) : WW'(1);
            end
        end
    end

    // R2: supply and output enable both active during a pulse
    a_r2_supply_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse_o |-> (vpp_en_o && oe_o));

    // R4: pulse width measured by the counter above
    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_prev_q && !prog_pulse_o) |-> (width_q == WW'(PULSE_CYC)));

    // R5: lines steady while pulse is high
    a_r5_lines_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_pulse_o && pulse_prev_q) |-> ($stable(prog_addr_o) && $stable(prog_data_o)));

    // R7: no acceptance window during a pulse
    a_r7_no_ready_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse_o |-> !in_ready_o);

    // R8: done lasts one cycle and the supply is already off
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !vpp_en_o);

    // R9: a refused pair never coincides with a pulse, flag lasts one cycle
    a_r9_err_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!prog_pulse_o && !$past(prog_pulse_o)));

    a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

endmodule

bind prom_burn_seq pbs_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_pulse_o (prog_pulse_o),
    .vpp_en_o     (vpp_en_o),
    .oe_o         (oe_o),
    .in_ready_o   (in_ready_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .prog_addr_o  (prog_addr_o),
    .prog_data_o  (prog_data_o)
);

// File: tb/prom_burn_seq_tb_top.sv
`timescale 1ns/1ps
module prom_burn_seq_tb_top;

    localparam int CLK_HZ = 20_000;
    localparam int PMS    = 50;
    localparam int S      = 3;
    localparam int H      = 2;
    localparam int P      = (CLK_HZ / 1000) * PMS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [11:0] in_addr_i = '0;
    logic [7:0]  in_data_i = '0;
    logic        in_last_i = 1'b0;
    logic        in_ready_o, prog_pulse_o, vpp_en_o, oe_o, busy_o, done_o, err_o;
    logic [10:0] prog_addr_o;
    logic [7:0]  prog_data_o;
    logic [11:0] count_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    prom_burn_seq #(
        .CLK_HZ(CLK_HZ), .PULSE_MS(PMS), .SETUP_CYC(S), .HOLD_CYC(H)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
        .in_addr_i(in_addr_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
        .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o),
        .prog_pulse_o(prog_pulse_o), .vpp_en_o(vpp_en_o), .oe_o(oe_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .count_o(count_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- output monitor ----------------
    int cyc = 0, t_addr = 0, t_data = 0, t_fall = 0, width = 0;
    int n_pulse = 0;
    bit hold_pend = 0;
    logic [10:0] prev_addr = '0;
    logic [7:0]  prev_data = '0;
    logic        prev_pulse = 0, prev_ready = 0;
    logic [10:0] pa [0:15];
    logic [7:0]  pd [0:15];

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prog_addr_o != prev_addr) t_addr = cyc;
            if (prog_data_o != prev_data) t_data = cyc;
            if (prog_pulse_o && !prev_pulse) begin
                chk(t_data - t_addr == S, "R3 addr-to-data cycles", t_data - t_addr, S);
                chk(cyc - t_data == S, "R5 data-to-pulse cycles", cyc - t_data, S);
                pa[n_pulse % 16] = prog_addr_o;
                pd[n_pulse % 16] = prog_data_o;
                n_pulse++;
                width = 0;
            end
            if (prog_pulse_o) begin
                width++;
                if (!(vpp_en_o && oe_o)) chk(0, "R2 enables during pulse", {vpp_en_o, oe_o}, 3);
            end
            if (!prog_pulse_o && prev_pulse) begin
                chk(width == P, "R4 pulse width", width, P);
                t_fall = cyc;
                hold_pend = 1;
            end
            if (hold_pend && ((in_ready_o && !prev_ready) || done_o)) begin
                chk(cyc - t_fall == H, "R6 hold cycles", cyc - t_fall, H);
                hold_pend = 0;
            end
            prev_addr  = prog_addr_o;
            prev_data  = prog_data_o;
            prev_pulse = prog_pulse_o;
            prev_ready = in_ready_o;
        end
    end

    // ---------------- helpers ----------------
    task automatic start_session();
        int k;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(vpp_en_o && oe_o && busy_o, "R2 enables after start", {vpp_en_o, oe_o, busy_o}, 7);
        chk(count_o == 0, "R10 count cleared at start", count_o, 0);
        k = 1;
        while (!in_ready_o && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(k == S + 1, "R2 cycles to ready", k, S + 1);
    endtask

    task automatic send_pair(input logic [11:0] a, input logic [7:0] d, input bit last);
        in_addr_i  = a;
        in_data_i  = d;
        in_last_i  = last;
        in_valid_i = 1'b1;
        while (!in_ready_o) @(negedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!done_o && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(done_o, "R8 done seen", done_o, 1);
        chk(!vpp_en_o, "R8 supply off at done", vpp_en_o, 0);
        @(negedge clk);
        chk(!done_o && !busy_o && !oe_o, "R8 idle after done", {done_o, busy_o, oe_o}, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk({prog_pulse_o, vpp_en_o, oe_o, in_ready_o, busy_o, done_o, err_o} == 0,
            "R1 reset controls", {prog_pulse_o, vpp_en_o, oe_o, in_ready_o, busy_o, done_o, err_o}, 0);
        chk(count_o == 0 && prog_addr_o == 0 && prog_data_o == 0, "R1 reset data",
            count_o + prog_addr_o + prog_data_o, 0);
    endtask

    task automatic t_single();
        int p0 = n_pulse;
        start_session();
        send_pair(12'h155, 8'hA5, 1'b1);
        chk(!in_ready_o, "R7 ready low after take", in_ready_o, 0);
        chk(prog_addr_o == 11'h155, "R3 address presented", prog_addr_o, 'h155);
        chk(prog_data_o == 8'h00, "R3 data not yet presented", prog_data_o, 0);
        wait_done();
        chk(n_pulse - p0 == 1, "R4 one pulse", n_pulse - p0, 1);
        chk(pa[p0 % 16] == 11'h155 && pd[p0 % 16] == 8'hA5, "R5 lines at pulse",
            {pa[p0 % 16], pd[p0 % 16]}, {11'h155, 8'hA5});
        chk(count_o == 1, "R10 count single", count_o, 1);
    endtask

    task automatic t_multi();
        int p0 = n_pulse;
        start_session();
        send_pair(12'h001, 8'h3C, 1'b0);
        send_pair(12'h7FF, 8'hC3, 1'b0);
        send_pair(12'h400, 8'h5A, 1'b1);
        wait_done();
        chk(n_pulse - p0 == 3, "R7 one pulse per pair", n_pulse - p0, 3);
        chk(pa[(p0 + 1) % 16] == 11'h7FF && pd[(p0 + 1) % 16] == 8'hC3, "R4 top location",
            pa[(p0 + 1) % 16], 'h7FF);
        chk(pa[(p0 + 2) % 16] == 11'h400 && pd[(p0 + 2) % 16] == 8'h5A, "R4 third pair",
            pa[(p0 + 2) % 16], 'h400);
        chk(count_o == 3, "R10 count multi", count_o, 3);
    endtask

    task automatic t_reject();
        int p0 = n_pulse;
        logic [10:0] a0;
        start_session();
        a0 = prog_addr_o;
        send_pair(12'h800, 8'hEE, 1'b0);
        chk(err_o, "R9 error raised", err_o, 1);
        @(negedge clk);
        chk(!err_o, "R9 error one cycle", err_o, 0);
        chk(prog_addr_o == a0, "R9 address kept", prog_addr_o, a0);
        chk(in_ready_o, "R9 still waiting", in_ready_o, 1);
        chk(n_pulse == p0 && count_o == 0, "R9 no pulse", n_pulse - p0, 0);
        send_pair(12'h0AA, 8'h11, 1'b1);
        wait_done();
        chk(count_o == 1 && n_pulse - p0 == 1, "R9 good pair after reject", count_o, 1);
        // session ended by a refused last pair
        p0 = n_pulse;
        start_session();
        send_pair(12'hFFF, 8'h22, 1'b1);
        chk(err_o, "R9 error on last", err_o, 1);
        wait_done();
        chk(n_pulse == p0 && count_o == 0, "R9 refused last no pulse", count_o, 0);
    endtask

    task automatic t_start_busy();
        start_session();
        send_pair(12'h123, 8'h44, 1'b0);
        while (!prog_pulse_o) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(prog_pulse_o && busy_o, "R11 start ignored in pulse", prog_pulse_o, 1);
        send_pair(12'h124, 8'h45, 1'b1);
        chk(count_o == 1, "R11 count not cleared", count_o, 1);
        wait_done();
        chk(count_o == 2, "R11 count after session", count_o, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_multi();
        t_reject();
        t_start_busy();
        repeat (4) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule